// File: doc/BRIEF.md
# Asynchronous handshake bus slave

This block is the slow-clock side of a link to an external controller that runs on an unrelated, faster clock. The controller drives six level strobes: clear, address, input-map write, kernel write, compute and result read. It shares one bidirectional data bus with the slave. Address, write data and read data all cross that bus, each in its own handshake phase. Every strobe is closed by a level acknowledge that follows the four-phase rule. Correct operation therefore depends only on the order of events and never on the ratio of the two clocks.

Inside the block, each strobe passes through a two-flop synchroniser. The slave latches the address word and stores write words into one of two small operand stores. On a compute request it waits a fixed latency and then produces one result word per entry. It returns results on the bus only during a read phase. A three-state controller (filling, busy, results) decides which requests are served.

Top module: `hs_bus_slave`

## Requirements
- R1: After `rst_n` low, or after the clear strobe `m_rst` is seen high through the synchroniser, `ack_addr`, `ack_wr`, `ack_rd` and `ready` are low, the controller is in the filling state and the bus is released.
- R2: A strobe is acted on only after two synchronising flops: when a strobe rises between clock edges, its acknowledge is still low after the second following rising edge and is high after the third.
- R3: While `m_addr` is seen high and `ack_addr` is low, the slave latches the low AW bits of the bus as the address and raises `ack_addr`.
- R4: `m_wr_in` stores the bus word into the input-map entry at the latched address, and `m_wr_kern` stores it into the kernel entry; either one then raises `ack_wr`. A write is accepted in the filling and results states and held off while busy. A write accepted in the results state returns the controller to filling and drops `ready`.
- R5: In the filling state `m_comp` starts a computation. CLAT cycles later every result entry i becomes the bitwise XNOR of input-map entry i and kernel entry i, and `ready` rises. `ready` then stays high until a write or a clear. In the results state `m_comp` has no effect.
- R6: `m_read` is served only in the results state: the slave drives result entry [latched address] on the bus and raises `ack_rd`. In the filling state a read strobe is never acknowledged.
- R7: The slave drives the bus only while `ack_rd` is high. Once `m_read` is seen low, it drops `ack_rd` and releases the bus on the same edge.
- R8: Each acknowledge stays high for as long as its synchronised strobe stays high, and falls after that strobe is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_rst | input | 1 | Clear strobe from controller (async) |
| m_addr | input | 1 | Address strobe (async) |
| m_wr_in | input | 1 | Input-map write strobe (async) |
| m_wr_kern | input | 1 | Kernel write strobe (async) |
| m_comp | input | 1 | Compute strobe (async) |
| m_read | input | 1 | Result read strobe (async) |
| dbus | inout | DW | Shared data bus |
| ack_addr | output | 1 | Address acknowledge |
| ack_wr | output | 1 | Write acknowledge |
| ack_rd | output | 1 | Read acknowledge, bus driven while high |
| ready | output | 1 | Results available |

## Verification
The assertions check on every cycle the relations that hold between strobes, acknowledges and controller state. An acknowledge rises only after its synchronised strobe. It holds while that strobe is high. A read is acknowledged only from the results state, and a write never while busy. The bus is released once the read strobe is seen low. A clear empties every output, and `ready` holds until a write or a clear. Only the bench scenarios can show the data path: the exact three-edge synchroniser latency, that every stored word lands at its latched address, that the XNOR results read back correctly across all entries and several patterns, and that an unserved read leaves the bus free.

// File: rtl/hs_bus_slave.sv
module hs_bus_slave #(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int CLAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_rst,
  input  logic          m_addr,
  input  logic          m_wr_in,
  input  logic          m_wr_kern,
  input  logic          m_comp,
  input  logic          m_read,
  inout  wire  [DW-1:0] dbus,
  output logic          ack_addr,
  output logic          ack_wr,
  output logic          ack_rd,
  output logic          ready
);
  localparam int DEPTH = 1 << AW;
  localparam int NS    = 6;
  localparam int CW    = $clog2(CLAT + 1);

  typedef enum logic [1:0] {ST_FILL, ST_BUSY, ST_RES} st_t;

  logic [NS-1:0] raw, s1, s2;
  logic          sr, sa, swi, swk, sc, srd;
  st_t           st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_q;
  logic [CW-1:0] cnt;
  logic          wr_go, rd_go, done;
  logic [DW-1:0] imap [DEPTH];
  logic [DW-1:0] kern [DEPTH];
  logic [DW-1:0] res  [DEPTH];

  assign raw = {m_read, m_comp, m_wr_kern, m_wr_in, m_addr, m_rst};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  assign sr  = s2[0];
  assign sa  = s2[1];
  assign swi = s2[2];
  assign swk = s2[3];
  assign sc  = s2[4];
  assign srd = s2[5];

  assign wr_go = (swi | swk) & ~ack_wr & (st != ST_BUSY) & ~sr;
  assign rd_go = srd & ~ack_rd & (st == ST_RES) & ~sr;
  assign done  = (st == ST_BUSY) && (cnt == CW'(CLAT - 1));
  assign ready = (st == ST_RES);
  assign dbus  = ack_rd ? rd_q : 'z;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_FILL;
      cnt      <= '0;
      addr_q   <= '0;
      rd_q     <= '0;
      ack_addr <= 1'b0;
      ack_wr   <= 1'b0;
      ack_rd   <= 1'b0;
    end else if (sr) begin
      st       <= ST_FILL;
      cnt      <= '0;
      ack_addr <= 1'b0;
      ack_wr   <= 1'b0;
      ack_rd   <= 1'b0;
    end else begin
      if (sa && !ack_addr) begin
        addr_q   <= dbus[AW-1:0];
        ack_addr <= 1'b1;
      end else if (!sa) begin
        ack_addr <= 1'b0;
      end

      if (wr_go)            ack_wr <= 1'b1;
      else if (!swi && !swk) ack_wr <= 1'b0;

      if (rd_go) begin
        ack_rd <= 1'b1;
        rd_q   <= res[addr_q];
      end else if (!srd) begin
        ack_rd <= 1'b0;
      end

      case (st)
        ST_FILL: if (sc) begin
          st  <= ST_BUSY;
          cnt <= '0;
        end
        ST_BUSY: if (done) st <= ST_RES;
                 else      cnt <= cnt + 1'b1;
        ST_RES:  if (wr_go) st <= ST_FILL;
        default: st <= ST_FILL;
      endcase
    end

  always_ff @(posedge clk) begin
    if (wr_go && swi) imap[addr_q] <= dbus;
    if (wr_go && swk) kern[addr_q] <= dbus;
    if (done && !sr)
      for (int i = 0; i < DEPTH; i++) res[i] <= ~(imap[i] ^ kern[i]);
  end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> (!ready && !ack_rd && !ack_wr && !ack_addr)); // R1
  AST_ADDR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_addr) |-> $past(sa)); // R3
  AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_wr) |-> ($past(st) != ST_BUSY && $past(swi | swk))); // R4
  AST_READY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_go && !sr) |=> ready); // R5
  AST_RD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_rd) |-> ($past(st) == ST_RES)); // R6
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !srd) |=> !ack_rd); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_addr && sa && !sr) |=> ack_addr); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (swi | swk) && !sr) |=> ack_wr); // R8
endmodule

// File: tb/test_hs_bus_slave.sv
module test_hs_bus_slave;
  localparam int DW = 16, AW = 3, CLAT = 4, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_rst = 0, m_addr = 0, m_wr_in = 0, m_wr_kern = 0, m_comp = 0, m_read = 0;
  logic mdrv = 1'b0;
  logic [DW-1:0] mdat = '0;
  wire  [DW-1:0] dbus;
  logic ack_addr, ack_wr, ack_rd, ready;
  int total = 0, bad = 0;

  assign dbus = mdrv ? mdat : 'z;
  always #4 clk = ~clk;

  hs_bus_slave #(.DW(DW), .AW(AW), .CLAT(CLAT)) i_hs_bus_slave (
    .clk(clk), .rst_n(rst_n), .m_rst(m_rst), .m_addr(m_addr), .m_wr_in(m_wr_in),
    .m_wr_kern(m_wr_kern), .m_comp(m_comp), .m_read(m_read), .dbus(dbus),
    .ack_addr(ack_addr), .ack_wr(ack_wr), .ack_rd(ack_rd), .ready(ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic sig(input int k);
    case (k)
      0: return ack_addr;
      1: return ack_wr;
      2: return ack_rd;
      default: return ready;
    endcase
  endfunction

  task automatic waitfor(input int k, input logic lvl, input string req);
    int n = 0;
    while (sig(k) !== lvl && n < 200) begin @(negedge clk); n++; end
    chk(req, {31'b0, sig(k)}, {31'b0, lvl});
  endtask

  task automatic bus_free(input string req);
    @(negedge clk); mdrv = 1; mdat = 16'h5A3C;
    @(negedge clk); chk(req, {16'b0, dbus}, {16'b0, 16'h5A3C});
    mdrv = 0;
  endtask

  task automatic do_addr(input int a);
    @(negedge clk); mdrv = 1; mdat = DW'(a); m_addr = 1;
    waitfor(0, 1, "R3 addr ack rise");
    m_addr = 0;
    waitfor(0, 0, "R8 addr ack fall");
    mdrv = 0;
  endtask

  task automatic do_write(input bit kernel, input int a, input logic [DW-1:0] d);
    do_addr(a);
    @(negedge clk); mdrv = 1; mdat = d;
    if (kernel) m_wr_kern = 1; else m_wr_in = 1;
    waitfor(1, 1, "R4 write ack rise");
    m_wr_kern = 0; m_wr_in = 0;
    waitfor(1, 0, "R8 write ack fall");
    mdrv = 0;
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] d);
    do_addr(a);
    @(negedge clk); m_read = 1;
    waitfor(2, 1, "R6 read ack rise");
    m_read = 0;
    d = dbus;
    waitfor(2, 0, "R7 read ack fall");
  endtask

  task automatic do_compute();
    @(negedge clk); m_comp = 1;
    waitfor(3, 1, "R5 ready rise");
    m_comp = 0;
  endtask

  function automatic logic [DW-1:0] pat_i(input int a, input int r);
    return DW'(a * 16'h1357) ^ DW'(r * 16'hA5C3);
  endfunction
  function automatic logic [DW-1:0] pat_k(input int a, input int r);
    return DW'(a * 16'h0F0F + r * 16'h3C96 + 1);
  endfunction

  initial begin
    #1200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset acks/ready", {28'b0, ack_addr, ack_wr, ack_rd, ready}, 32'h0);
    bus_free("R7 bus free after reset");

    // R2: latency through two synchronising flops
    @(negedge clk); mdrv = 1; mdat = 16'h0002; m_addr = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 ack low after two edges", {31'b0, ack_addr}, 32'h0);
    @(negedge clk);
    chk("R2 ack high after third edge", {31'b0, ack_addr}, 32'h1);
    m_addr = 0;
    waitfor(0, 0, "R8 addr ack fall");
    mdrv = 0;

    // R6: read in filling state is not served, bus stays free
    @(negedge clk); m_read = 1;
    repeat (20) @(negedge clk);
    chk("R6 no read ack in filling", {31'b0, ack_rd}, 32'h0);
    m_read = 0;
    repeat (3) @(negedge clk);
    bus_free("R7 bus free after unserved read");

    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < DEPTH; a++) begin
        do_write(0, a, pat_i(a, r));
        do_write(1, a, pat_k(a, r));
      end
      chk("R5 ready low before compute", {31'b0, ready}, 32'h0);
      do_compute();
      repeat (5) @(negedge clk);
      chk("R5 ready holds", {31'b0, ready}, 32'h1);
      for (int a = DEPTH - 1; a >= 0; a--) begin
        do_read(a, d);
        chk("R6 result word", {16'b0, d}, {16'b0, ~(pat_i(a, r) ^ pat_k(a, r))});
      end
      repeat (3) @(negedge clk);
      bus_free("R7 bus free after read");
      // compute strobe in results state: no effect
      @(negedge clk); m_comp = 1;
      repeat (10) @(negedge clk);
      chk("R5 compute ignored in results", {31'b0, ready}, 32'h1);
      m_comp = 0;
      do_read(1, d);
      chk("R5 results unchanged", {16'b0, d}, {16'b0, ~(pat_i(1, r) ^ pat_k(1, r))});
      // write in results returns to filling
      do_write(0, 0, 16'hFFFF);
      chk("R4 write in results drops ready", {31'b0, ready}, 32'h0);
    end

    // R4: single changed entry after recompute
    do_compute();
    do_read(0, d);
    chk("R4 updated entry", {16'b0, d}, {16'b0, pat_k(0, 1)});
    do_read(2, d);
    chk("R4 other entry kept", {16'b0, d}, {16'b0, ~(pat_i(2, 1) ^ pat_k(2, 1))});

    // R1: clear strobe in results state
    @(negedge clk); m_rst = 1;
    repeat (4) @(negedge clk);
    chk("R1 clear strobe", {28'b0, ack_addr, ack_wr, ack_rd, ready}, 32'h0);
    m_rst = 0;
    repeat (3) @(negedge clk);
    @(negedge clk); m_read = 1;
    repeat (10) @(negedge clk);
    chk("R1 filling after clear", {31'b0, ack_rd}, 32'h0);
    m_read = 0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule